// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the register file that a processor programs before a four-channel DMA transfer begins. The processor reaches it through 8-bit reads and writes on a 16-location port space. For every channel the block keeps a 16-bit start address and a 16-bit transfer count, each held twice: a base copy and a working (current) copy. It also keeps a small page value that supplies the upper physical address bits, a mode field and a mask bit. The transfer sequencer reads all of these from wide output buses. As the transfer runs, the sequencer writes back the working address and count and reports when a channel reaches terminal count.

Each channel's 16-bit registers sit behind a single byte port, so software reaches them in two accesses. One byte pointer, shared by all eight address and count ports, decides whether an access hits the low or the high half. Software resets that pointer through a dedicated port. The mask and mode ports take the channel number from the data byte, so one port location serves all four channels. A status port reports latched terminal-count flags together with the live request lines, and reading it clears the flags.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1, every address, count, page and mode value is zero, the terminal-count flags are clear and the byte pointer selects the low byte.
- R2: A write to port 2n (address) or 2n+1 (count), n = 0..3, loads the selected byte into both the base and the current copy of that channel's register.
- R3: The byte pointer is shared by ports 0..7 and toggles on every read or write to any of them: low byte first, high byte second, then back to low.
- R4: Any write to port 0Ch returns the byte pointer to the low byte, whatever the data value.
- R5: Reads of ports 0..7 return the current copy of the selected register, the byte chosen by the pointer.
- R6: A write to port 0Ah sets (bit 2 = 1) or clears (bit 2 = 0) the mask of the channel named by data bits [1:0]. All other mask bits and data bits have no effect.
- R7: A write to port 0Bh stores data bits [7:2] as the mode of the channel in bits [1:0]. The fields are [7:6] mode (00 demand, 01 single, 10 block, 11 cascade), [5] decrement, [4] auto-initialize, and [3:2] direction (00 verify, 01 device to memory, 10 memory to device). Channel c's field is ch_mode[6c+5:6c].
- R8: A page write stores pg_data as the page of channel pg_chan. The page is presented on ch_page[4c+3:4c].
- R9: A sequencer update loads seq_addr and seq_count into the current copies of seq_chan and leaves the base copies unchanged.
- R10: Port 08h reads {dreq[3:0], tc_flags[3:0]} and the read clears every flag. A seq_tc pulse sets the flag of seq_chan one cycle later, and this set wins over a clearing read in the same cycle.
- R11: When a processor byte write and a sequencer update hit the same register in the same cycle, the processor byte is merged into the current copy and the sequencer value for that register is dropped. The other register of the channel still takes the sequencer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe |
| rd_en | input | 1 | Processor read strobe |
| port_addr | input | 4 | Processor port address |
| wdata | input | 8 | Processor write data |
| rdata | output | 8 | Processor read data (combinational) |
| pg_wr | input | 1 | Page register write strobe |
| pg_chan | input | 2 | Page register channel |
| pg_data | input | PAGE_W | Page value |
| dreq | input | 4 | Live channel request lines |
| seq_upd | input | 1 | Sequencer current-register update |
| seq_tc | input | 1 | Sequencer terminal-count pulse |
| seq_chan | input | 2 | Channel for sequencer update / terminal count |
| seq_addr | input | 16 | Updated current address |
| seq_count | input | 16 | Updated current count |
| ch_addr | output | 64 | Current addresses, channel c at [16c+15:16c] |
| ch_count | output | 64 | Current counts |
| ch_base_addr | output | 64 | Base addresses |
| ch_base_count | output | 64 | Base counts |
| ch_page | output | 4*PAGE_W | Page values |
| ch_mode | output | 24 | Mode fields, 6 bits per channel |
| ch_mask | output | 4 | Channel masks |
| tc_flags | output | 4 | Latched terminal-count flags |

## Verification
Two situations are hard to reach from the ports. The first is a collision in one cycle between a processor byte write and a sequencer update on the same channel. The bench drives both strobes in a single cycle and expects a byte-merged address while the count still takes the sequencer value. The second is a terminal-count pulse that arrives in the same cycle as a status read. The bench pulses seq_tc while reading status and checks that the read shows the old flags and the new flag survives. Because the byte pointer is shared, the bench also interleaves accesses to different channels and uses reads to move the pointer, so that a following write is expected to land on the high byte.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int REG_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [3:0] PORT_STATUS = 4'h8;
    localparam logic [3:0] PORT_MASK   = 4'hA;
    localparam logic [3:0] PORT_MODE   = 4'hB;
    localparam logic [3:0] PORT_CLRPTR = 4'hC;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        XD_VERIFY   = 2'b00,
        XD_TO_MEM   = 2'b01,
        XD_FROM_MEM = 2'b10,
        XD_RSVD     = 2'b11
    } xfer_dir_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       dec;
        logic       autoinit;
        xfer_dir_e  dir;
    } chan_mode_t;

    localparam int MODE_W = $bits(chan_mode_t);

    // Replace one half of a 16-bit register with a byte.
    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] old,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
        return hi ? {b, old[BYTE_W-1:0]} : {old[REG_W-1:BYTE_W], b};
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [REG_W-1:0] w,
                                                   input logic hi);
        return hi ? w[REG_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dmareg_byteptr.sv
module dmareg_byteptr (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst)        hi <= 1'b0;
        else if (clear) hi <= 1'b0;
        else if (step)  hi <= ~hi;
    end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hi,
    input  logic [BYTE_W-1:0]     wbyte,
    input  logic                  addr_wr,
    input  logic                  cnt_wr,
    input  logic                  seq_upd,
    input  logic [REG_W-1:0]      seq_addr,
    input  logic [REG_W-1:0]      seq_count,
    input  logic                  mode_wr,
    input  chan_mode_t            mode_in,
    input  logic                  mask_wr,
    input  logic                  mask_in,
    input  logic                  page_wr,
    input  logic [PAGE_W-1:0]     page_in,
    output logic [REG_W-1:0]      cur_addr,
    output logic [REG_W-1:0]      cur_cnt,
    output logic [REG_W-1:0]      base_addr,
    output logic [REG_W-1:0]      base_cnt,
    output chan_mode_t            mode,
    output logic                  mask,
    output logic [PAGE_W-1:0]     page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            base_addr <= '0;
            base_cnt  <= '0;
            mode      <= '0;
            mask      <= 1'b1;
            page      <= '0;
        end else begin
            // processor byte write has priority over the sequencer
            if (addr_wr) begin
                base_addr <= put_byte(base_addr, wbyte, hi);
                cur_addr  <= put_byte(cur_addr, wbyte, hi);
            end else if (seq_upd) begin
                cur_addr  <= seq_addr;
            end
            if (cnt_wr) begin
                base_cnt <= put_byte(base_cnt, wbyte, hi);
                cur_cnt  <= put_byte(cur_cnt, wbyte, hi);
            end else if (seq_upd) begin
                cur_cnt  <= seq_count;
            end
            if (mode_wr) mode <= mode_in;
            if (mask_wr) mask <= mask_in;
            if (page_wr) page <= page_in;
        end
    end
endmodule

// File: rtl/dmareg_status.sv
module dmareg_status
    import dmareg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_clr,
    input  logic [NCH-1:0] tc_set,
    output logic [NCH-1:0] tc
);
    always_ff @(posedge clk) begin
        if (rst) tc <= '0;
        else     tc <= (rd_clr ? '0 : tc) | tc_set;
    end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [3:0]                port_addr,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [BYTE_W-1:0]         rdata,
    input  logic                      pg_wr,
    input  logic [CHW-1:0]            pg_chan,
    input  logic [PAGE_W-1:0]         pg_data,
    input  logic [NCH-1:0]            dreq,
    input  logic                      seq_upd,
    input  logic                      seq_tc,
    input  logic [CHW-1:0]            seq_chan,
    input  logic [REG_W-1:0]          seq_addr,
    input  logic [REG_W-1:0]          seq_count,
    output logic [NCH*REG_W-1:0]      ch_addr,
    output logic [NCH*REG_W-1:0]      ch_count,
    output logic [NCH*REG_W-1:0]      ch_base_addr,
    output logic [NCH*REG_W-1:0]      ch_base_count,
    output logic [NCH*PAGE_W-1:0]     ch_page,
    output logic [NCH*MODE_W-1:0]     ch_mode,
    output logic [NCH-1:0]            ch_mask,
    output logic [NCH-1:0]            tc_flags
);
    // decode of the channel register ports 0 .. 2*NCH-1
    logic           reg_port;
    logic [CHW-1:0] sel_ch;
    logic           sel_cnt;
    logic           ptr_hi;
    logic           ptr_clear;
    logic           ptr_step;
    logic           rd_clr;
    logic [NCH-1:0] tc_set;

    assign reg_port  = (port_addr < 4'(2*NCH));
    assign sel_ch    = port_addr[CHW:1];
    assign sel_cnt   = port_addr[0];
    assign ptr_step  = reg_port && (wr_en || rd_en);
    assign ptr_clear = wr_en && (port_addr == PORT_CLRPTR);
    assign rd_clr    = rd_en && (port_addr == PORT_STATUS);

    always_comb begin
        tc_set = '0;
        if (seq_tc) tc_set[seq_chan] = 1'b1;
    end

    dmareg_byteptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .step  (ptr_step),
        .clear (ptr_clear),
        .hi    (ptr_hi)
    );

    dmareg_status u_status (
        .clk    (clk),
        .rst    (rst),
        .rd_clr (rd_clr),
        .tc_set (tc_set),
        .tc     (tc_flags)
    );

    logic [REG_W-1:0] cur_a [NCH];
    logic [REG_W-1:0] cur_c [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_mode_t mode_q;

        dmareg_chan #(.PAGE_W(PAGE_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .hi        (ptr_hi),
            .wbyte     (wdata),
            .addr_wr   (wr_en && reg_port && (sel_ch == CHW'(i)) && !sel_cnt),
            .cnt_wr    (wr_en && reg_port && (sel_ch == CHW'(i)) &&  sel_cnt),
            .seq_upd   (seq_upd && (seq_chan == CHW'(i))),
            .seq_addr  (seq_addr),
            .seq_count (seq_count),
            .mode_wr   (wr_en && (port_addr == PORT_MODE) && (wdata[CHW-1:0] == CHW'(i))),
            .mode_in   (chan_mode_t'(wdata[BYTE_W-1:CHW])),
            .mask_wr   (wr_en && (port_addr == PORT_MASK) && (wdata[CHW-1:0] == CHW'(i))),
            .mask_in   (wdata[CHW]),
            .page_wr   (pg_wr && (pg_chan == CHW'(i))),
            .page_in   (pg_data),
            .cur_addr  (cur_a[i]),
            .cur_cnt   (cur_c[i]),
            .base_addr (ch_base_addr[i*REG_W +: REG_W]),
            .base_cnt  (ch_base_count[i*REG_W +: REG_W]),
            .mode      (mode_q),
            .mask      (ch_mask[i]),
            .page      (ch_page[i*PAGE_W +: PAGE_W])
        );

        assign ch_addr[i*REG_W +: REG_W]   = cur_a[i];
        assign ch_count[i*REG_W +: REG_W]  = cur_c[i];
        assign ch_mode[i*MODE_W +: MODE_W] = mode_q;
    end

    always_comb begin
        rdata = '0;
        if (reg_port)
            rdata = get_byte(sel_cnt ? cur_c[sel_ch] : cur_a[sel_ch], ptr_hi);
        else if (port_addr == PORT_STATUS)
            rdata = {dreq, tc_flags};
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
    import dmareg_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [3:0]            port_addr,
    input logic [BYTE_W-1:0]     wdata,
    input logic                  pg_wr,
    input logic [CHW-1:0]        pg_chan,
    input logic [PAGE_W-1:0]     pg_data,
    input logic                  seq_upd,
    input logic                  seq_tc,
    input logic [CHW-1:0]        seq_chan,
    input logic [REG_W-1:0]      seq_addr,
    input logic [REG_W-1:0]      seq_count,
    input logic [NCH*REG_W-1:0]  ch_addr,
    input logic [NCH*REG_W-1:0]  ch_count,
    input logic [NCH*PAGE_W-1:0] ch_page,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_mask,
    input logic [NCH-1:0]        tc_flags
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_mask == '1 && tc_flags == '0 && ch_addr == '0 && ch_count == '0));

    // R4
    clear_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && port_addr == PORT_CLRPTR) && wr_en && port_addr == 4'h0 && !seq_upd)
        |=> ch_addr[REG_W-1:BYTE_W] == $past(ch_addr[REG_W-1:BYTE_W]));

    // R6
    mask_port_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == PORT_MASK)
        |=> ch_mask[$past(wdata[CHW-1:0])] == $past(wdata[CHW]));

    // R7
    mode_port_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == PORT_MODE)
        |=> ch_mode[int'($past(wdata[CHW-1:0]))*MODE_W +: MODE_W] == $past(wdata[BYTE_W-1:CHW]));

    // R8
    page_port_chk: assert property (@(posedge clk) disable iff (rst)
        pg_wr |=> ch_page[int'($past(pg_chan))*PAGE_W +: PAGE_W] == $past(pg_data));

    // R9
    seq_update_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_upd && !(wr_en && port_addr < 4'(2*NCH)))
        |=> (ch_addr[int'($past(seq_chan))*REG_W +: REG_W] == $past(seq_addr) &&
             ch_count[int'($past(seq_chan))*REG_W +: REG_W] == $past(seq_count)));

    // R10
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        seq_tc |=> tc_flags[$past(seq_chan)]);

    // R10
    tc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_addr == PORT_STATUS && !seq_tc) |=> tc_flags == '0);

endmodule

bind dma_regfile dma_regfile_chk #(.PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;
    import dmareg_pkg::*;

    localparam int CLK_P  = 10;
    localparam int PAGE_W = 4;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]            port_addr = '0;
    logic [7:0]            wdata = '0;
    logic [7:0]            rdata;
    logic                  pg_wr = 1'b0;
    logic [1:0]            pg_chan = '0;
    logic [PAGE_W-1:0]     pg_data = '0;
    logic [3:0]            dreq = '0;
    logic                  seq_upd = 1'b0, seq_tc = 1'b0;
    logic [1:0]            seq_chan = '0;
    logic [15:0]           seq_addr = '0, seq_count = '0;
    logic [63:0]           ch_addr, ch_count, ch_base_addr, ch_base_count;
    logic [4*PAGE_W-1:0]   ch_page;
    logic [23:0]           ch_mode;
    logic [3:0]            ch_mask, tc_flags;

    dma_regfile #(.PAGE_W(PAGE_W)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errs   = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R5 unexpected read", {56'd0, rdata}, 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                eq(it.tag, {56'd0, rdata}, {56'd0, it.exp});
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; port_addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic cpu_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; port_addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(CLK_P * 50000);
        chk(1'b0, "R1 watchdog", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        eq("R1 mask", ch_mask, 4'hF);
        eq("R1 addr", ch_addr, 64'd0);
        eq("R1 count", ch_count, 64'd0);
        eq("R1 mode", ch_mode, 24'd0);
        eq("R1 page", ch_page, '0);
        eq("R1 tc", tc_flags, 4'd0);
        cpu_rd(4'h8, 8'h00, "R1 status");

        // R2 address and count load base and current
        cpu_wr(4'hC, 8'hA5);
        cpu_wr(4'h4, 8'h00);
        cpu_wr(4'h4, 8'h10);
        eq("R2 cur addr ch2", ch_addr[47:32], 16'h1000);
        eq("R2 base addr ch2", ch_base_addr[47:32], 16'h1000);
        cpu_wr(4'h5, 8'hFF);
        cpu_wr(4'h5, 8'h01);
        eq("R2 cur count ch2", ch_count[47:32], 16'h01FF);
        eq("R2 base count ch2", ch_base_count[47:32], 16'h01FF);

        // R3 pointer is shared across channels
        cpu_wr(4'hC, 8'h00);
        cpu_wr(4'h2, 8'h34);
        cpu_wr(4'h7, 8'h12);
        eq("R3 ch3 count high", ch_count[63:48], 16'h1200);
        eq("R3 ch1 addr low", ch_addr[31:16], 16'h0034);
        cpu_wr(4'h2, 8'h56);
        eq("R3 ch1 addr wraps to low", ch_addr[31:16], 16'h0056);

        // R4 clear port resets the pointer whatever the data
        cpu_wr(4'hC, 8'h00);
        cpu_wr(4'h0, 8'hAA);
        cpu_wr(4'hC, 8'hFF);
        cpu_wr(4'h0, 8'h55);
        eq("R4 ch0 addr", ch_addr[15:0], 16'h0055);

        // R5 reads return current copy through pointer
        cpu_wr(4'hC, 8'h00);
        cpu_rd(4'h4, 8'h00, "R5 ch2 addr lo");
        cpu_rd(4'h4, 8'h10, "R5 ch2 addr hi");
        cpu_rd(4'h5, 8'hFF, "R5 ch2 count lo");
        cpu_rd(4'h5, 8'h01, "R5 ch2 count hi");
        cpu_rd(4'h1, 8'h00, "R5 ch0 count lo");
        cpu_wr(4'h1, 8'h77);
        eq("R3 read moves pointer", ch_count[15:0], 16'h7700);

        // R6 single mask port
        cpu_wr(4'hA, 8'h02);
        eq("R6 clear ch2", ch_mask, 4'hB);
        cpu_wr(4'hA, 8'hF9);
        eq("R6 clear ch1 upper bits ignored", ch_mask, 4'h9);
        cpu_wr(4'hA, 8'h06);
        eq("R6 set ch2", ch_mask, 4'hD);

        // R7 mode port
        cpu_wr(4'hB, 8'h46);
        eq("R7 ch2 single to-mem", ch_mode[17:12], 6'h11);
        cpu_wr(4'hB, 8'hE3);
        eq("R7 ch3 cascade dec", ch_mode[23:18], 6'h38);
        eq("R7 ch2 kept", ch_mode[17:12], 6'h11);

        // R8 page registers
        pg_wr = 1'b1; pg_chan = 2'd2; pg_data = 4'h7;
        tick();
        pg_chan = 2'd0; pg_data = 4'hC;
        tick();
        pg_wr = 1'b0;
        eq("R8 page ch2", ch_page[11:8], 4'h7);
        eq("R8 page ch0", ch_page[3:0], 4'hC);

        // R9 sequencer update
        seq_upd = 1'b1; seq_chan = 2'd2; seq_addr = 16'h1001; seq_count = 16'h01FE;
        tick();
        seq_upd = 1'b0;
        eq("R9 cur addr", ch_addr[47:32], 16'h1001);
        eq("R9 cur count", ch_count[47:32], 16'h01FE);
        eq("R9 base addr kept", ch_base_addr[47:32], 16'h1000);
        eq("R9 base count kept", ch_base_count[47:32], 16'h01FF);

        // R11 collision of processor byte and sequencer update
        cpu_wr(4'hC, 8'h00);
        seq_upd = 1'b1; seq_chan = 2'd2; seq_addr = 16'h2222; seq_count = 16'h0033;
        cpu_wr(4'h4, 8'h20);
        seq_upd = 1'b0;
        eq("R11 addr merged", ch_addr[47:32], 16'h1020);
        eq("R11 count from seq", ch_count[47:32], 16'h0033);
        eq("R11 base addr", ch_base_addr[47:32], 16'h1020);

        // R10 status and terminal count
        dreq = 4'b0101;
        seq_tc = 1'b1; seq_chan = 2'd1;
        tick();
        seq_tc = 1'b0;
        cpu_rd(4'h8, 8'h52, "R10 status with tc1");
        cpu_rd(4'h8, 8'h50, "R10 tc cleared by read");
        begin
            item_t it;
            it.exp = 8'h50; it.tag = "R10 read during tc";
            sb.push_back(it);
            rd_en = 1'b1; port_addr = 4'h8; seq_tc = 1'b1; seq_chan = 2'd3;
            tick();
            rd_en = 1'b0; seq_tc = 1'b0;
        end
        eq("R10 set wins over clear", tc_flags, 4'h8);
        cpu_rd(4'h8, 8'h58, "R10 status tc3");
        cpu_rd(4'h8, 8'h50, "R10 cleared again");

        tick();
        eq("R5 scoreboard drained", sb.size(), 0);
        summary();
        $finish;
    end
endmodule